// File: doc/BRIEF.md
# Dual-Mode Reset Controller

This block turns one active-low reset pin and one level-sensed interrupt pin into a set of domain resets and a reset-exception request for the processor. The level of the interrupt pin at the start of a reset picks the kind of reset. A high level gives a full power-on reset, which clears the processor core, the general peripherals and a protected group: the bus controller, the break controller and the clock-frequency register. A low level gives a manual reset, which clears only the core and the general peripherals. Because the bus controller is left alone, memory refresh keeps running through a long manual reset.

Both pins pass through synchronizers. A low pulse counts as a reset only once it has lasted the qualification length, and shorter pulses leave every output untouched. When the pin returns high after a qualified low period, the domain resets release and an exception request is raised together with the reset type. The request and the type stay put until the processor acknowledges. A manual reset that ends while a bus cycle is open keeps the domains in reset and holds back the request until the bus reports that the cycle is done.

Top module: `rst_mode_ctrl`

## Requirements
- R1: With the interrupt pin high at the first synchronized low sample, a qualified reset asserts all three domain resets (core, peripheral, protected) and reports resetType = 0 (power-on).
- R2: With the interrupt pin low at the first synchronized low sample, a qualified reset asserts the core and peripheral resets, leaves the protected reset deasserted, and reports resetType = 1 (manual).
- R3: A reset is qualified only when the synchronized reset is low for at least QUAL_CYCLES (20) samples. A pulse of 19 clock cycles asserts no domain reset and raises no request. A pulse of exactly 20 cycles is qualified.
- R4: Domain resets are asserted from qualification until the request is raised. While the request is high, all domain resets are deasserted.
- R5: The exception request is raised only after the synchronized reset has returned high, never while it is low, and no sooner than two clock cycles after the pin rises.
- R6: A manual reset released while busBusy is high and busDone is low holds the request low and the core reset asserted until a busDone pulse. The request follows within two cycles of that pulse.
- R7: A power-on reset ignores busBusy and raises the request without any busDone.
- R8: excReq and resetType hold their values until excAck is sampled high. excReq is low from the cycle after the acknowledge.
- R9: The reset type is fixed by the interrupt level at the first low sample. A change of the interrupt pin later in the same reset does not change resetType or the set of domains reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstInN | input | 1 | Raw active-low reset pin, asynchronous |
| nmiIn | input | 1 | Raw interrupt level that selects the reset type, asynchronous |
| busBusy | input | 1 | High while a bus cycle is in progress |
| busDone | input | 1 | One-cycle pulse when the open bus cycle completes |
| excAck | input | 1 | Processor acknowledge of the exception request |
| coreRstN | output | 1 | Active-low reset for the processor core |
| periphRstN | output | 1 | Active-low reset for the general peripherals |
| protRstN | output | 1 | Active-low reset for the bus controller, break controller and frequency register |
| excReq | output | 1 | Reset-exception request, held until acknowledged |
| resetType | output | 1 | 0 for power-on, 1 for manual; valid while excReq is high |

## Verification
The reset pin is driven with lows of 19, 20 and 25 cycles. These separate pulses that are ignored from pulses that qualify, right at the count boundary. Each qualified length is run with the interrupt pin high and with it low, which separates a full reset from one that spares the protected group. A further case flips the interrupt pin part-way through a reset to show that only the first low sample decides the type. Releases with the bus busy and with it idle, under both reset types, separate the held request from the immediate one. Acknowledges given late show that the request and the type persist until they are taken.

// File: rtl/rst_mode_pkg.sv
package rst_mode_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_BUSWAIT = 2'd2,
    ST_REQ     = 2'd3
  } rstState_e;

  // Strobes from control to datapath: next values of the output registers
  typedef struct packed {
    logic holdMain;     // core and peripheral domains in reset next cycle
    logic holdProt;     // protected domain in reset next cycle
    logic captureType;  // load the reset type from the latched interrupt level
    logic raiseReq;     // exception request high next cycle
  } rstStrobe_t;

endpackage

// File: rtl/rst_mode_datapath.sv
module rst_mode_datapath
  import rst_mode_pkg::*;
#(
  parameter int QUAL_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstInN,
  input  logic       nmiIn,
  input  rstStrobe_t strobe,
  output logic       rstSync,
  output logic       qualEdge,
  output logic       nmiHeld,
  output logic       coreRstN,
  output logic       periphRstN,
  output logic       protRstN,
  output logic       excReq,
  output logic       resetType
);

  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(QUAL_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [SYNC_STAGES-1:0] rstPipe;
  logic [SYNC_STAGES-1:0] nmiPipe;

  // Synchronizer chains, one flop per stage
  always_ff @(posedge clk) begin
    rstPipe[0] <= rstInN;
    nmiPipe[0] <= nmiIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        rstPipe[s] <= rstPipe[s-1];
        nmiPipe[s] <= nmiPipe[s-1];
      end
    end
  endgenerate

  logic nmiSync;
  assign rstSync = rstPipe[SYNC_STAGES-1];
  assign nmiSync = nmiPipe[SYNC_STAGES-1];

  // Low-time counter: saturates, clears while reset is high
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rstSync) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign qualEdge = !rstSync && (lowCnt == CNT_LAST);

  // Interrupt level taken on the first low sample of each reset
  always_ff @(posedge clk) begin
    if (!rstSync && lowCnt == '0) begin
      nmiHeld <= nmiSync;
    end
  end

  // Output registers, stored as active-high hold flags
  logic mainHold;
  logic periphHold;
  logic protHold;

  always_ff @(posedge clk) begin
    mainHold   <= strobe.holdMain;
    periphHold <= strobe.holdMain;
    protHold   <= strobe.holdProt;
    excReq     <= strobe.raiseReq;
    if (strobe.captureType) begin
      resetType <= !nmiHeld;
    end
  end

  assign coreRstN   = !mainHold;
  assign periphRstN = !periphHold;
  assign protRstN   = !protHold;

  AST_TYPE_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstInN)
    (!rstSync && lowCnt != '0) |=> $stable(nmiHeld)) else $error("nmi latch moved"); // R9

  AST_PROT_ONLY_POWERON: assert property (@(posedge clk) disable iff (!rstInN)
    !protRstN |-> !resetType) else $error("protected reset in manual"); // R2

  AST_QUALIFIED_ENTRY: assert property (@(posedge clk) disable iff (!rstInN)
    $fell(coreRstN) |-> (lowCnt == CNT_MAX)) else $error("unqualified reset"); // R3

  AST_DOMAINS_FREE_ON_REQ: assert property (@(posedge clk) disable iff (!rstInN)
    excReq |-> (coreRstN && periphRstN && protRstN)) else $error("domain held during req"); // R4

endmodule

// File: rtl/rst_mode_fsm.sv
module rst_mode_fsm
  import rst_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstInN,
  input  logic       rstSync,
  input  logic       qualEdge,
  input  logic       nmiHeld,
  input  logic       resetType,
  input  logic       excReq,
  input  logic       busBusy,
  input  logic       busDone,
  input  logic       excAck,
  output rstStrobe_t strobe
);

  rstState_e state;
  rstState_e stateNext;
  logic      manualNow;

  // Type in force: fresh from the latch on entry, else the stored one
  assign manualNow = (state == ST_IDLE) ? !nmiHeld : resetType;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (qualEdge) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (rstSync) begin
          if (manualNow && busBusy && !busDone) stateNext = ST_BUSWAIT;
          else                                  stateNext = ST_REQ;
        end
      end
      ST_BUSWAIT: begin
        if (busDone) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (excAck || !rstSync) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    state <= stateNext;
  end

  logic holdingNext;
  assign holdingNext = (stateNext == ST_HOLD) || (stateNext == ST_BUSWAIT);

  always_comb begin
    strobe.holdMain    = holdingNext;
    strobe.holdProt    = holdingNext && !manualNow;
    strobe.captureType = (state == ST_IDLE) && (stateNext == ST_HOLD);
    strobe.raiseReq    = (stateNext == ST_REQ);
  end

  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstInN)
    excReq |-> rstSync) else $error("request while in reset"); // R5

  AST_BUS_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rstInN)
    (state == ST_BUSWAIT && !busDone) |=> !excReq) else $error("request before bus done"); // R6

  AST_POWERON_NO_WAIT: assert property (@(posedge clk) disable iff (!rstInN)
    (state == ST_HOLD && rstSync && !resetType) |=> excReq) else $error("power-on request late"); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstInN)
    (excReq && !excAck && rstSync) |=> (excReq && $stable(resetType))) else $error("request dropped"); // R8

endmodule

// File: rtl/rst_mode_ctrl.sv
module rst_mode_ctrl
  import rst_mode_pkg::*;
#(
  parameter int QUAL_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstInN,
  input  logic nmiIn,
  input  logic busBusy,
  input  logic busDone,
  input  logic excAck,
  output logic coreRstN,
  output logic periphRstN,
  output logic protRstN,
  output logic excReq,
  output logic resetType
);

  rstStrobe_t strobe;
  logic       rstSync;
  logic       qualEdge;
  logic       nmiHeld;

  rst_mode_datapath #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstInN    (rstInN),
    .nmiIn     (nmiIn),
    .strobe    (strobe),
    .rstSync   (rstSync),
    .qualEdge  (qualEdge),
    .nmiHeld   (nmiHeld),
    .coreRstN  (coreRstN),
    .periphRstN(periphRstN),
    .protRstN  (protRstN),
    .excReq    (excReq),
    .resetType (resetType)
  );

  rst_mode_fsm u_fsm (
    .clk      (clk),
    .rstInN   (rstInN),
    .rstSync  (rstSync),
    .qualEdge (qualEdge),
    .nmiHeld  (nmiHeld),
    .resetType(resetType),
    .excReq   (excReq),
    .busBusy  (busBusy),
    .busDone  (busDone),
    .excAck   (excAck),
    .strobe   (strobe)
  );

endmodule

// File: tb/tb_rst_mode_ctrl.sv
module tb_rst_mode_ctrl;

  logic clk = 1'b0;
  logic rstInN = 1'b1;
  logic nmiIn = 1'b1;
  logic busBusy = 1'b0;
  logic busDone = 1'b0;
  logic excAck = 1'b0;
  logic coreRstN, periphRstN, protRstN, excReq, resetType;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rst_mode_ctrl dut (
    .clk(clk), .rstInN(rstInN), .nmiIn(nmiIn), .busBusy(busBusy),
    .busDone(busDone), .excAck(excAck), .coreRstN(coreRstN),
    .periphRstN(periphRstN), .protRstN(protRstN), .excReq(excReq),
    .resetType(resetType)
  );

  // Sticky monitors, cleared by tasks
  logic sawReq = 1'b0;
  logic sawCore = 1'b0;
  always @(posedge clk) begin
    if (excReq) sawReq <= 1'b1;
    if (!coreRstN || !periphRstN || !protRstN) sawCore <= 1'b1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic holdLow(input int cycles);
    @(negedge clk);
    rstInN = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // Releases reset and returns the number of cycles until excReq (99 if none)
  task automatic releaseWait(input int limit, output int lat);
    rstInN = 1'b1;
    lat = 99;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (excReq) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic ackReq();
    excAck = 1'b1;
    @(negedge clk);
    excAck = 1'b0;
    check(!excReq, "R8 req drops after ack", excReq, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic testPowerOn();
    int lat;
    nmiIn = 1'b1;
    holdLow(25);
    check(!coreRstN && !periphRstN && !protRstN, "R1 all domains asserted",
          {coreRstN, periphRstN, protRstN}, 0);
    check(!excReq, "R5 no request while low", excReq, 0);
    releaseWait(8, lat);
    check(lat >= 2 && lat <= 5, "R5 request after release", lat, 3);
    check(resetType == 1'b0, "R1 type power-on", resetType, 0);
    check(coreRstN && periphRstN && protRstN, "R4 domains released with request",
          {coreRstN, periphRstN, protRstN}, 7);
    repeat (4) @(negedge clk);
    check(excReq && !resetType, "R8 request held without ack", excReq, 1);
    ackReq();
  endtask

  task automatic testManual();
    int lat;
    nmiIn = 1'b0;
    holdLow(25);
    check(!coreRstN && !periphRstN, "R2 core and periph asserted",
          {coreRstN, periphRstN}, 0);
    check(protRstN, "R2 protected untouched", protRstN, 1);
    releaseWait(8, lat);
    check(lat <= 5, "R2 manual request raised", lat, 3);
    check(resetType == 1'b1, "R2 type manual", resetType, 1);
    ackReq();
    nmiIn = 1'b1;
  endtask

  task automatic testShortPulse();
    int lat;
    sawReq = 1'b0;
    sawCore = 1'b0;
    holdLow(19);
    releaseWait(30, lat);
    check(!sawCore, "R3 19-cycle pulse asserts no domain", sawCore, 0);
    check(!sawReq && lat == 99, "R3 19-cycle pulse raises no request", sawReq, 0);
    holdLow(20);
    releaseWait(8, lat);
    check(lat <= 5, "R3 20-cycle pulse qualifies", lat, 3);
    ackReq();
  endtask

  task automatic testBusWait();
    int lat;
    nmiIn = 1'b0;
    busBusy = 1'b1;
    holdLow(25);
    releaseWait(10, lat);
    check(lat == 99 && !excReq, "R6 request held while bus busy", excReq, 0);
    check(!coreRstN, "R6 core stays in reset during bus wait", coreRstN, 0);
    busDone = 1'b1;
    @(negedge clk);
    busDone = 1'b0;
    busBusy = 1'b0;
    @(negedge clk);
    check(excReq && resetType, "R6 request after bus done", excReq, 1);
    ackReq();
    nmiIn = 1'b1;
  endtask

  task automatic testPowerOnBusy();
    int lat;
    nmiIn = 1'b1;
    busBusy = 1'b1;
    holdLow(25);
    releaseWait(8, lat);
    check(lat <= 5, "R7 power-on ignores busy bus", lat, 3);
    busBusy = 1'b0;
    ackReq();
  endtask

  task automatic testNmiChange();
    int lat;
    nmiIn = 1'b1;
    holdLow(5);
    nmiIn = 1'b0;
    repeat (20) @(negedge clk);
    check(!protRstN, "R9 late nmi drop keeps full reset", protRstN, 0);
    releaseWait(8, lat);
    check(excReq && !resetType, "R9 type stays power-on", resetType, 0);
    ackReq();
    nmiIn = 1'b0;
    holdLow(5);
    nmiIn = 1'b1;
    repeat (20) @(negedge clk);
    check(protRstN, "R9 late nmi rise keeps protected free", protRstN, 1);
    releaseWait(8, lat);
    check(excReq && resetType, "R9 type stays manual", resetType, 1);
    ackReq();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(coreRstN && protRstN && !excReq, "R4 idle before any reset",
          {coreRstN, protRstN, excReq}, 6);
    testPowerOn();
    testManual();
    testShortPulse();
    testBusWait();
    testPowerOnBusy();
    testNmiChange();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule